// File: doc/BRIEF.md
# Three-Mode Countdown Timer

This block is a reloadable down-counter with one waveform output. It runs in one of three modes: a one-shot pulse, a periodic rate generator that emits a one-tick dip every N+1 ticks, and a square-wave generator with a 50% duty cycle. A host writes a reload value N and a control word through simple write strobes. The control word holds the mode, a run bit, a count-hold bit, an output-inversion bit and an interrupt-enable bit. All timing runs off the system clock `clk`. It advances only on cycles where the timer-clock enable `tick` is high.

Two gate inputs and the hold bit can freeze the sequence without losing its place. The live count is visible on a port. A sticky event flag records terminal counts, or in square-wave mode the falling edges of the output. The host clears the flag by writing a one to the acknowledge strobe. The interrupt line shows the flag only while interrupts are enabled.

Top module: `cdtimer`

## Requirements
- R1: After synchronous reset `tmr_out`, `irq`, `irq_flag`, `running` and `count` are all 0. With `inv`=0 the idle output level is 0.
- R2: One-shot mode (mode code 2'b00). The first unpaused tick after the run bit is set loads N into `count` and drives the active level. The output stays active for max(N,1) ticks and then returns inactive. After load tick k, `count` equals max(N-k,0).
- R3: In one-shot mode the run bit (`running`) clears itself on the tick that reaches terminal count.
- R4: Rate-generator mode (2'b01), with M = max(N,1). Counting from the load tick as k=0, the output is active when k mod (M+1) < M and inactive for the one remaining tick. `count` equals max(N - k mod (M+1), 0).
- R5: Square-wave mode (2'b10 and 2'b11). The output is active when floor(k/(N+1)) is even, so it toggles every N+1 ticks. `count` equals N - k mod (N+1).
- R6: While the hold bit, `gate0` or `gate1` is high, ticks leave `count` and `tmr_out` unchanged. Counting resumes from the same point afterwards.
- R7: A tick sets `irq_flag` at these events: terminal count in one-shot and rate modes, and each active-to-inactive output transition in square-wave mode. The flag stays set until `irq_ack` is pulsed. A set and an acknowledge on the same cycle leave the flag set.
- R8: `irq` is high exactly when `irq_flag` is set and the enable bit is 1.
- R9: With `inv`=1, `tmr_out` is the complement of the active-high waveform in every mode, including idle.
- R10: Clearing the run bit has no effect on the output until the next tick. That tick forces the output inactive and ends the sequence.
- R11: A reload write while running does not change `count`. The new N is used only at the next load or reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable, one pulse per timer period |
| reload_we | input | 1 | Write strobe for the reload value |
| reload_din | input | W | Reload value N |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_mode | input | 2 | 00 one-shot, 01 rate, 1x square |
| ctrl_run | input | 1 | Run bit |
| ctrl_hold | input | 1 | Count-hold bit |
| ctrl_inv | input | 1 | Output inversion |
| ctrl_ien | input | 1 | Interrupt enable |
| gate0 | input | 1 | External pause, active high |
| gate1 | input | 1 | External pause, active high |
| irq_ack | input | 1 | Write-one-to-clear for the event flag |
| tmr_out | output | 1 | Waveform output |
| irq | output | 1 | Interrupt line |
| irq_flag | output | 1 | Sticky event flag |
| running | output | 1 | Current run bit |
| count | output | W | Current counter value |

## Verification
A bad count or a missed reload shows on `count` at the very next tick. It then pushes the next edge of `tmr_out` off its computed tick within one period of N+1 ticks. A wrong phase flip-flop inverts the waveform or puts the square-wave flag on the rising instead of the falling edge, and this is visible within two half-periods. A lost load state shows either as a missing active level on the tick after start or as a run bit that fails to drop at one-shot terminal count.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    MD_ONE  = 2'b00,
    MD_RATE = 2'b01,
    MD_SQ   = 2'b10,
    MD_SQX  = 2'b11
  } cdt_mode_e;
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reload_we,
  input  logic [W-1:0]        reload_din,
  input  logic                ctrl_we,
  input  logic [1:0]          ctrl_mode,
  input  logic                ctrl_run,
  input  logic                ctrl_hold,
  input  logic                ctrl_inv,
  input  logic                ctrl_ien,
  input  logic                run_clr,
  output logic [W-1:0]        nval_q,
  output cdt_pkg::cdt_mode_e  mode_q,
  output logic                run_q,
  output logic                hold_q,
  output logic                inv_q,
  output logic                ien_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      nval_q <= '0;
      mode_q <= cdt_pkg::MD_ONE;
      run_q  <= 1'b0;
      hold_q <= 1'b0;
      inv_q  <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (reload_we) nval_q <= reload_din;
      if (ctrl_we) begin
        mode_q <= cdt_pkg::cdt_mode_e'(ctrl_mode);
        run_q  <= ctrl_run;
        hold_q <= ctrl_hold;
        inv_q  <= ctrl_inv;
        ien_q  <= ctrl_ien;
      end else if (run_clr) begin
        run_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cdt_core.sv
module cdt_core #(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               pause,
  input  logic               run_q,
  input  cdt_pkg::cdt_mode_e mode_q,
  input  logic [W-1:0]       nval_q,
  output logic [W-1:0]       cnt_q,
  output logic               lvl_q,
  output logic               run_clr,
  output logic               evt
);
  import cdt_pkg::*;

  logic loaded_q;
  logic adv;
  logic term_le1;
  logic term_zero;

  assign adv       = tick && run_q && !pause;
  assign term_le1  = (cnt_q <= W'(1));
  assign term_zero = (cnt_q == '0);

  always_comb begin
    run_clr = 1'b0;
    evt     = 1'b0;
    if (adv && loaded_q) begin
      unique case (mode_q)
        MD_ONE: begin
          run_clr = term_le1;
          evt     = term_le1;
        end
        MD_RATE: evt = lvl_q && term_le1;
        default: evt = lvl_q && term_zero;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      lvl_q    <= 1'b0;
      loaded_q <= 1'b0;
    end else if (tick) begin
      if (!run_q) begin
        lvl_q    <= 1'b0;
        loaded_q <= 1'b0;
      end else if (!pause) begin
        if (!loaded_q) begin
          cnt_q    <= nval_q;
          lvl_q    <= 1'b1;
          loaded_q <= 1'b1;
        end else begin
          unique case (mode_q)
            MD_ONE: begin
              if (term_le1) begin
                cnt_q    <= '0;
                lvl_q    <= 1'b0;
                loaded_q <= 1'b0;
              end else begin
                cnt_q <= cnt_q - W'(1);
              end
            end
            MD_RATE: begin
              if (!lvl_q) begin
                cnt_q <= nval_q;
                lvl_q <= 1'b1;
              end else if (term_le1) begin
                cnt_q <= '0;
                lvl_q <= 1'b0;
              end else begin
                cnt_q <= cnt_q - W'(1);
              end
            end
            default: begin
              if (term_zero) begin
                cnt_q <= nval_q;
                lvl_q <= !lvl_q;
              end else begin
                cnt_q <= cnt_q - W'(1);
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic ack,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)       flag_q <= 1'b0;
    else if (evt)  flag_q <= 1'b1;
    else if (ack)  flag_q <= 1'b0;
  end
endmodule

// File: rtl/cdtimer.sv
module cdtimer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         reload_we,
  input  logic [W-1:0] reload_din,
  input  logic         ctrl_we,
  input  logic [1:0]   ctrl_mode,
  input  logic         ctrl_run,
  input  logic         ctrl_hold,
  input  logic         ctrl_inv,
  input  logic         ctrl_ien,
  input  logic         gate0,
  input  logic         gate1,
  input  logic         irq_ack,
  output logic         tmr_out,
  output logic         irq,
  output logic         irq_flag,
  output logic         running,
  output logic [W-1:0] count
);
  logic [W-1:0]       nval_q;
  cdt_pkg::cdt_mode_e mode_q;
  logic               run_q, hold_q, inv_q, ien_q;
  logic               pause, run_clr, evt, lvl_q, flag_q;
  logic [W-1:0]       cnt_q;

  assign pause = hold_q || gate0 || gate1;

  cdt_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst),
    .reload_we(reload_we), .reload_din(reload_din),
    .ctrl_we(ctrl_we), .ctrl_mode(ctrl_mode), .ctrl_run(ctrl_run),
    .ctrl_hold(ctrl_hold), .ctrl_inv(ctrl_inv), .ctrl_ien(ctrl_ien),
    .run_clr(run_clr),
    .nval_q(nval_q), .mode_q(mode_q), .run_q(run_q),
    .hold_q(hold_q), .inv_q(inv_q), .ien_q(ien_q)
  );

  cdt_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .pause(pause),
    .run_q(run_q), .mode_q(mode_q), .nval_q(nval_q),
    .cnt_q(cnt_q), .lvl_q(lvl_q), .run_clr(run_clr), .evt(evt)
  );

  cdt_irq u_irq (
    .clk(clk), .rst(rst), .evt(evt), .ack(irq_ack), .flag_q(flag_q)
  );

  assign tmr_out  = lvl_q ^ inv_q;
  assign irq      = flag_q && ien_q;
  assign irq_flag = flag_q;
  assign running  = run_q;
  assign count    = cnt_q;
endmodule

// File: rtl/cdtimer_chk.sv
module cdtimer_chk #(
  parameter int W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               ctrl_we,
  input logic               irq_ack,
  input logic               pause,
  input logic               run_q,
  input logic               lvl_q,
  input cdt_pkg::cdt_mode_e mode_q,
  input logic               tmr_out,
  input logic               irq_flag,
  input logic [W-1:0]       count
);
  // R6: a paused tick while running changes neither count nor output
  a_r6_pause_freeze: assert property (@(posedge clk) disable iff (rst)
    (tick && pause && run_q && !ctrl_we) |=> ($stable(count) && $stable(tmr_out)));

  // R3: one-shot terminal (active level falling) clears the run bit
  a_r3_oneshot_selfclear: assert property (@(posedge clk) disable iff (rst)
    ($fell(lvl_q) && mode_q == cdt_pkg::MD_ONE && !$past(ctrl_we)) |-> !run_q);

  // R7: the flag is sticky until acknowledged
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !irq_ack) |=> irq_flag);

  // R10: a tick with the run bit clear leaves the waveform inactive
  a_r10_stop_inactive: assert property (@(posedge clk) disable iff (rst)
    (tick && !run_q) |=> !lvl_q);

  // R2: the counter only moves on a timer tick
  a_r2_count_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));
endmodule

bind cdtimer cdtimer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .ctrl_we(ctrl_we), .irq_ack(irq_ack),
  .pause(pause), .run_q(run_q), .lvl_q(lvl_q), .mode_q(mode_q),
  .tmr_out(tmr_out), .irq_flag(irq_flag), .count(count)
);

// File: tb/cdtimer_test.sv
module cdtimer_test;
  localparam int W = 4;
  localparam int NMAX = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, reload_we = 1'b0, ctrl_we = 1'b0;
  logic [W-1:0] reload_din = '0;
  logic [1:0] ctrl_mode = 2'b00;
  logic ctrl_run = 1'b0, ctrl_hold = 1'b0, ctrl_inv = 1'b0, ctrl_ien = 1'b0;
  logic gate0 = 1'b0, gate1 = 1'b0, irq_ack = 1'b0;
  logic tmr_out, irq, irq_flag, running;
  logic [W-1:0] count;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cdtimer #(.W(W)) uut (
    .clk(clk), .rst(rst), .tick(tick),
    .reload_we(reload_we), .reload_din(reload_din),
    .ctrl_we(ctrl_we), .ctrl_mode(ctrl_mode), .ctrl_run(ctrl_run),
    .ctrl_hold(ctrl_hold), .ctrl_inv(ctrl_inv), .ctrl_ien(ctrl_ien),
    .gate0(gate0), .gate1(gate1), .irq_ack(irq_ack),
    .tmr_out(tmr_out), .irq(irq), .irq_flag(irq_flag),
    .running(running), .count(count)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_tick(input logic ack);
    tick = 1'b1; irq_ack = ack; cyc();
    tick = 1'b0; irq_ack = 1'b0; cyc();
  endtask

  task automatic wr_ctrl(input int m, input logic run, input logic hold,
                         input logic inv, input logic ien);
    ctrl_mode = 2'(m); ctrl_run = run; ctrl_hold = hold;
    ctrl_inv = inv; ctrl_ien = ien; ctrl_we = 1'b1; cyc();
    ctrl_we = 1'b0; cyc();
  endtask

  task automatic wr_n(input int n);
    reload_din = W'(n); reload_we = 1'b1; cyc();
    reload_we = 1'b0; cyc();
  endtask

  task automatic ack_only();
    irq_ack = 1'b1; cyc(); irq_ack = 1'b0; cyc();
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0; cyc();
    // R1: reset state
    chk("R1 out", tmr_out, 0);
    chk("R1 irq", irq, 0);
    chk("R1 flag", irq_flag, 0);
    chk("R1 running", running, 0);
    chk("R1 count", count, 0);

    // Sweep: all modes, every N, both polarities (R2 R3 R4 R5 R7 R8 R9)
    for (int inv = 0; inv < 2; inv++) begin
      for (int m = 0; m < 4; m++) begin
        for (int n = 0; n <= NMAX; n++) begin
          int me, p, len, el, ec, ef;
          wr_ctrl(m, 1'b0, 1'b0, inv[0], 1'b1);
          do_tick(1'b1);
          ack_only();
          wr_n(n);
          chk("R9 idle", tmr_out, inv);
          wr_ctrl(m, 1'b1, 1'b0, inv[0], 1'b1);
          me = (n < 1) ? 1 : n;
          if (m == 0)      begin p = 0;       len = me + 3; end
          else if (m == 1) begin p = me + 1;  len = 2 * p + 1; end
          else             begin p = n + 1;   len = 2 * p + 2; end
          for (int k = 0; k < len; k++) begin
            do_tick(1'b1);
            if (m == 0) begin
              el = (k < me) ? 1 : 0;
              ec = (n - k > 0) ? n - k : 0;
              ef = (k == me) ? 1 : 0;
              chk("R2 out", tmr_out, el ^ inv);
              chk("R2 count", count, ec);
            end else if (m == 1) begin
              el = ((k % p) < me) ? 1 : 0;
              ec = (n - (k % p) > 0) ? n - (k % p) : 0;
              ef = ((k % p) == me) ? 1 : 0;
              chk("R4 out", tmr_out, el ^ inv);
              chk("R4 count", count, ec);
            end else begin
              el = (((k / p) % 2) == 0) ? 1 : 0;
              ec = n - (k % p);
              ef = (k > 0 && (k % p) == 0 && ((k / p) % 2) == 1) ? 1 : 0;
              chk("R5 out", tmr_out, el ^ inv);
              chk("R5 count", count, ec);
            end
            chk("R7 flag", irq_flag, ef);
            chk("R8 irq", irq, ef);
          end
          if (m == 0) chk("R3 running", running, 0);
          else        chk("R3 running periodic", running, 1);
        end
      end
    end

    // R6: pause by gate0, gate1 and hold bit in square mode, N=3
    wr_ctrl(2, 1'b0, 1'b0, 1'b0, 1'b0); do_tick(1'b1);
    wr_n(3);
    wr_ctrl(2, 1'b1, 1'b0, 1'b0, 1'b0);
    do_tick(1'b1); do_tick(1'b1);
    chk("R6 pre count", count, 2);
    gate0 = 1'b1;
    for (int i = 0; i < 3; i++) begin
      do_tick(1'b1);
      chk("R6 gate0 count", count, 2);
      chk("R6 gate0 out", tmr_out, 1);
    end
    gate0 = 1'b0; gate1 = 1'b1;
    do_tick(1'b1);
    chk("R6 gate1 count", count, 2);
    gate1 = 1'b0;
    wr_ctrl(2, 1'b1, 1'b1, 1'b0, 1'b0);
    do_tick(1'b1);
    chk("R6 hold count", count, 2);
    chk("R6 hold out", tmr_out, 1);
    wr_ctrl(2, 1'b1, 1'b0, 1'b0, 1'b0);
    do_tick(1'b1);
    chk("R6 resume count", count, 1);
    do_tick(1'b1); do_tick(1'b1);
    chk("R6 resume toggle", tmr_out, 0);

    // R10: stop in rate mode, inactive only at next tick
    wr_ctrl(1, 1'b0, 1'b0, 1'b0, 1'b0); do_tick(1'b1);
    wr_n(3);
    wr_ctrl(1, 1'b1, 1'b0, 1'b0, 1'b0);
    do_tick(1'b1); do_tick(1'b1);
    wr_ctrl(1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 before tick", tmr_out, 1);
    do_tick(1'b1);
    chk("R10 after tick", tmr_out, 0);
    do_tick(1'b1); do_tick(1'b1);
    chk("R10 stays", tmr_out, 0);
    chk("R10 running", running, 0);

    // R11: reload write mid-run in rate mode (3 then 5)
    wr_n(3);
    wr_ctrl(1, 1'b1, 1'b0, 1'b0, 1'b0);
    do_tick(1'b1); do_tick(1'b1);
    wr_n(5);
    chk("R11 count held", count, 2);
    do_tick(1'b1);
    chk("R11 old count", count, 1);
    do_tick(1'b1);
    chk("R11 old low", tmr_out, 0);
    do_tick(1'b1);
    chk("R11 new load", count, 5);
    chk("R11 high", tmr_out, 1);
    for (int i = 0; i < 4; i++) do_tick(1'b1);
    chk("R11 still high", tmr_out, 1);
    do_tick(1'b1);
    chk("R11 new low", tmr_out, 0);

    // R7 / R8: sticky flag, enable gating, acknowledge
    wr_ctrl(0, 1'b0, 1'b0, 1'b0, 1'b0); do_tick(1'b1); ack_only();
    wr_n(2);
    wr_ctrl(0, 1'b1, 1'b0, 1'b0, 1'b0);
    do_tick(1'b0); do_tick(1'b0); do_tick(1'b0);
    chk("R7 set", irq_flag, 1);
    chk("R8 masked", irq, 0);
    do_tick(1'b0);
    chk("R7 sticky", irq_flag, 1);
    wr_ctrl(0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 enabled", irq, 1);
    ack_only();
    chk("R7 cleared", irq_flag, 0);
    chk("R8 cleared", irq, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule